// File: doc/BRIEF.md
# Mixed-Width Byte-Lane RAM

This block is a single-clock RAM. Its storage is an array of narrow units, 8-bit bytes by default, and three ports of different widths share that one array. A wide write port updates a group of adjacent units in one cycle, and each lane of that group has its own enable bit. A narrow read port returns one unit. A wide read port returns the whole group that a single word address selects.

Each wide port is built from lanes. The unit address of lane `i` is the wide address in the upper bits with the constant `i` appended below it. Lane 0 holds the lowest slice of the wide word, and each higher lane holds the next slice up. Both read ports are registered, so data appears one cycle after the enable. When a read and a write hit the same unit in the same cycle, the read returns the contents from before the write.

The defaults are 256 units of 8 bits and a wide ratio of 4, which gives a 32-bit wide word. The wide address is 6 bits and the narrow address is 8 bits. The storage itself has no reset and starts with undefined contents. Only the read registers are reset.

Top module: `mwram_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `nrd_data` and `wrd_data` become 0 after that edge.
- R2: Wide word `w` consists of units `w*RATIO + i`, for `i` from 0 to RATIO-1. Lane `i` occupies bits `[i*UNIT_W +: UNIT_W]` of the wide data.
- R3: At a rising edge, for each bit `i` set in `wr_en`, unit `{wr_addr, i}` takes lane `i` of `wr_data`. Units whose enable bit is low keep their contents.
- R4: When `nrd_en` is high at an edge, `nrd_data` holds unit `nrd_addr` after that edge.
- R5: When `wrd_en` is high at an edge, `wrd_data` holds the wide word `wrd_addr` after that edge, assembled as R2 describes.
- R6: When `nrd_en` is low at an edge, `nrd_data` keeps its value, whatever `nrd_addr` is.
- R7: When `wrd_en` is low at an edge, `wrd_data` keeps its value, whatever `wrd_addr` is.
- R8: A narrow read of a unit that is written in the same cycle returns the contents from before the write (read-first).
- R9: A wide read of a word whose lanes are written in the same cycle returns the contents from before the write (read-first).
- R10: When both reads are enabled on the same word in the same cycle, `nrd_data` equals lane `nrd_addr[LANE_BITS-1:0]` of `wrd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes and reads occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| wr_en | input | RATIO | Per-lane write enables |
| wr_addr | input | ADDR_W-LANE_BITS | Wide write word address |
| wr_data | input | UNIT_W*RATIO | Wide write data, lane 0 in the low bits |
| nrd_en | input | 1 | Narrow read enable |
| nrd_addr | input | ADDR_W | Narrow read unit address |
| nrd_data | output | UNIT_W | Registered narrow read data |
| wrd_en | input | 1 | Wide read enable |
| wrd_addr | input | ADDR_W-LANE_BITS | Wide read word address |
| wrd_data | output | UNIT_W*RATIO | Registered wide read data |

## Verification
A write can fall in the same cycle as either read, and the two reads can fall in the same cycle as each other. The bench provokes each case by driving a full-lane write to a word together with a narrow read of one of its units, and then together with a wide read of that word. The read result is compared with the value held before the write, and a read in the following cycle must return the new value. In a separate step the bench enables both reads on one word at the same time and checks that both agree with the bench's own byte model.

// File: rtl/mwram_lane_addr.sv
// mwram_lane_addr: turns one wide word address into RATIO unit addresses.
// The unit address of lane i is {base, i}.
// Assumes RATIO == 2**LANE_BITS and LANE_BITS >= 1.
module mwram_lane_addr #(
    parameter int ADDR_W    = 8,
    parameter int LANE_BITS = 2,
    localparam int RATIO    = 1 << LANE_BITS,
    localparam int BASE_W   = ADDR_W - LANE_BITS
) (
    input  logic [BASE_W-1:0]       base,
    output logic [RATIO*ADDR_W-1:0] unit_addr
);
    genvar i;
    generate
        for (i = 0; i < RATIO; i++) begin : g_lane
            // place the constant lane index in the low bits of this lane's address
            assign unit_addr[i*ADDR_W +: ADDR_W] = {base, LANE_BITS'(i)};
        end
    endgenerate
endmodule

// File: rtl/mwram_store.sv
// mwram_store: the array of narrow units. It has one lane-enabled write
// and two registered reads (one unit and RATIO units).
// Assumes DEPTH == 2**ADDR_W and that the write lane addresses are distinct.
// Reads are read-first. The storage is not reset; the read registers are
// reset synchronously to 0.
module mwram_store #(
    parameter int UNIT_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int LANE_BITS = 2,
    localparam int RATIO    = 1 << LANE_BITS,
    localparam int DEPTH    = 1 << ADDR_W,
    localparam int WIDE_W   = UNIT_W * RATIO
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [RATIO-1:0]        wr_lane_en,
    input  logic [RATIO*ADDR_W-1:0] wr_unit_addr,
    input  logic [WIDE_W-1:0]       wr_data,
    input  logic                    nrd_en,
    input  logic [ADDR_W-1:0]       nrd_addr,
    output logic [UNIT_W-1:0]       nrd_data,
    input  logic                    wrd_en,
    input  logic [RATIO*ADDR_W-1:0] wrd_unit_addr,
    output logic [WIDE_W-1:0]       wrd_data
);
    logic [UNIT_W-1:0] mem [DEPTH];

    // store every enabled lane into its unit
    always_ff @(posedge clk) begin
        for (int i = 0; i < RATIO; i++) begin
            if (wr_lane_en[i])
                mem[wr_unit_addr[i*ADDR_W +: ADDR_W]] <= wr_data[i*UNIT_W +: UNIT_W];
        end
    end

    // narrow read register: reset to zero, load on enable, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            nrd_data <= '0;
        else if (nrd_en)
            nrd_data <= mem[nrd_addr];
    end

    // wide read register: gather all lanes of the word under one enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            wrd_data <= '0;
        else if (wrd_en) begin
            for (int i = 0; i < RATIO; i++)
                wrd_data[i*UNIT_W +: UNIT_W] <= mem[wrd_unit_addr[i*ADDR_W +: ADDR_W]];
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (nrd_data == '0 && wrd_data == '0));

    assert_narrow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nrd_en |=> $stable(nrd_data));

    assert_wide_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrd_en |=> $stable(wrd_data));

    assert_reads_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nrd_en && wrd_en &&
         nrd_addr[ADDR_W-1:LANE_BITS] == wrd_unit_addr[ADDR_W-1:LANE_BITS])
        |=> nrd_data == UNIT_W'(wrd_data >> (int'($past(nrd_addr[LANE_BITS-1:0])) * UNIT_W)));
endmodule

// File: rtl/mwram_top.sv
// mwram_top: a RAM with a lane-enabled wide write port and two registered
// read ports, one narrow and one wide, all on one clock.
// Assumes RATIO is a power of two, at least 2, and DEPTH is a power of two.
module mwram_top #(
    parameter int UNIT_W    = 8,
    parameter int DEPTH     = 256,
    parameter int RATIO     = 4,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int LANE_BITS = $clog2(RATIO),
    localparam int BASE_W    = ADDR_W - LANE_BITS,
    localparam int WIDE_W    = UNIT_W * RATIO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATIO-1:0]  wr_en,
    input  logic [BASE_W-1:0] wr_addr,
    input  logic [WIDE_W-1:0] wr_data,
    input  logic              nrd_en,
    input  logic [ADDR_W-1:0] nrd_addr,
    output logic [UNIT_W-1:0] nrd_data,
    input  logic              wrd_en,
    input  logic [BASE_W-1:0] wrd_addr,
    output logic [WIDE_W-1:0] wrd_data
);
    logic [RATIO*ADDR_W-1:0] wr_unit_addr;
    logic [RATIO*ADDR_W-1:0] wrd_unit_addr;

    mwram_lane_addr #(.ADDR_W(ADDR_W), .LANE_BITS(LANE_BITS)) u_wr_lanes (
        .base(wr_addr), .unit_addr(wr_unit_addr));

    mwram_lane_addr #(.ADDR_W(ADDR_W), .LANE_BITS(LANE_BITS)) u_rd_lanes (
        .base(wrd_addr), .unit_addr(wrd_unit_addr));

    mwram_store #(.UNIT_W(UNIT_W), .ADDR_W(ADDR_W), .LANE_BITS(LANE_BITS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_lane_en(wr_en), .wr_unit_addr(wr_unit_addr), .wr_data(wr_data),
        .nrd_en(nrd_en), .nrd_addr(nrd_addr), .nrd_data(nrd_data),
        .wrd_en(wrd_en), .wrd_unit_addr(wrd_unit_addr), .wrd_data(wrd_data));

    // a wide read starting in a cycle without reset sets every lane from storage
    assert_wide_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrd_en && !$isunknown(wrd_addr)) |=> !$isunknown(wrd_data));
endmodule

// File: tb/tb_mwram_top.sv
module tb_mwram_top;
    localparam int UW = 8;
    localparam int DP = 256;
    localparam int RT = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  wr_en;
    logic [5:0]  wr_addr;
    logic [31:0] wr_data;
    logic        nrd_en;
    logic [7:0]  nrd_addr;
    logic [7:0]  nrd_data;
    logic        wrd_en;
    logic [5:0]  wrd_addr;
    logic [31:0] wrd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0]  bm [DP];
    logic [7:0]  exp_n;
    logic [31:0] exp_w;

    always #4 clk = ~clk;

    mwram_top #(.UNIT_W(UW), .DEPTH(DP), .RATIO(RT)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .nrd_en(nrd_en), .nrd_addr(nrd_addr), .nrd_data(nrd_data),
        .wrd_en(wrd_en), .wrd_addr(wrd_addr), .wrd_data(wrd_data));

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 29 + 7 + salt * 101) & 255);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one clock cycle of stimulus; expectations are read-first against the model
    task automatic cyc(input logic [3:0] we, input logic [5:0] wa, input logic [31:0] wd,
                       input logic ne, input logic [7:0] na,
                       input logic re, input logic [5:0] ra,
                       input string tn, input string tw);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        nrd_en = ne; nrd_addr = na; wrd_en = re; wrd_addr = ra;
        @(posedge clk);
        if (ne) exp_n = bm[na];
        if (re) for (int i = 0; i < RT; i++) exp_w[i*8 +: 8] = bm[int'(ra) * RT + i];
        for (int i = 0; i < RT; i++) if (we[i]) bm[int'(wa) * RT + i] = wd[i*8 +: 8];
        #1;
        check(tn, {24'd0, nrd_data}, {24'd0, exp_n});
        check(tw, wrd_data, exp_w);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = '0; nrd_en = 1'b0; wrd_en = 1'b0;
        @(posedge clk);
        #1;
        exp_n = '0; exp_w = '0;
        check("R1 narrow", {24'd0, nrd_data}, 32'd0);
        check("R1 wide", wrd_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] word_pat(input int w, input int salt);
        logic [31:0] v;
        for (int i = 0; i < RT; i++) v[i*8 +: 8] = pat(w * RT + i, salt);
        return v;
    endfunction

    initial begin
        rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0;
        nrd_en = 1'b0; nrd_addr = '0; wrd_en = 1'b0; wrd_addr = '0;
        exp_n = '0; exp_w = '0;
        repeat (3) @(posedge clk);
        do_reset();
        // R3: fill every word with all lanes enabled; reads stay idle (R6, R7)
        for (int w = 0; w < 64; w++)
            cyc(4'hF, 6'(w), word_pat(w, 0), 1'b0, 8'(w), 1'b0, 6'(w), "R6 idle", "R7 idle");
        // R4: narrow sweep of every unit
        for (int a = 0; a < DP; a++)
            cyc(4'h0, 6'd0, 32'd0, 1'b1, 8'(a), 1'b0, 6'(a), "R4 narrow", "R7 hold");
        // R5 R2: wide sweep with lane ordering
        for (int w = 0; w < 64; w++)
            cyc(4'h0, 6'd0, 32'd0, 1'b0, 8'(w), 1'b1, 6'(w), "R6 hold", "R5 R2 wide");
        // R3: every subset of lane enables, then read back the word
        for (int m = 0; m < 16; m++) begin
            cyc(4'(m), 6'(10 + m), word_pat(10 + m, 1), 1'b0, 8'd0, 1'b0, 6'd0, "R6", "R7");
            cyc(4'h0, 6'd0, 32'd0, 1'b0, 8'd0, 1'b1, 6'(10 + m), "R6", "R3 lanes");
        end
        // R8: narrow read collides with a write to the same unit
        for (int k = 0; k < RT; k++) begin
            cyc(4'hF, 6'(40 + k), word_pat(40 + k, 2), 1'b1, 8'((40 + k) * RT + k), 1'b0, 6'd0,
                "R8 collide", "R7");
            cyc(4'h0, 6'd0, 32'd0, 1'b1, 8'((40 + k) * RT + k), 1'b0, 6'd0, "R3 after", "R7");
        end
        // R9: wide read collides with a partial and a full write to the same word
        cyc(4'h5, 6'd50, word_pat(50, 3), 1'b0, 8'd0, 1'b1, 6'd50, "R6", "R9 collide");
        cyc(4'h0, 6'd0, 32'd0, 1'b0, 8'd0, 1'b1, 6'd50, "R6", "R3 after");
        cyc(4'hF, 6'd51, word_pat(51, 3), 1'b0, 8'd0, 1'b1, 6'd51, "R6", "R9 collide");
        cyc(4'h0, 6'd0, 32'd0, 1'b0, 8'd0, 1'b1, 6'd51, "R6", "R3 after");
        // R10: both reads on one word in the same cycle
        for (int k = 0; k < RT; k++)
            cyc(4'h0, 6'd0, 32'd0, 1'b1, 8'(33 * RT + k), 1'b1, 6'd33, "R10 narrow", "R10 wide");
        // R6 R7: enables low with new addresses, outputs hold
        cyc(4'h0, 6'd0, 32'd0, 1'b0, 8'd200, 1'b0, 6'd60, "R6 addr change", "R7 addr change");
        do_reset();
        cyc(4'h0, 6'd0, 32'd0, 1'b0, 8'd7, 1'b0, 6'd7, "R6 after reset", "R7 after reset");
        cyc(4'h0, 6'd0, 32'd0, 1'b1, 8'd7, 1'b1, 6'd1, "R4 after reset", "R5 after reset");
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule